// File: doc/BRIEF.md
# Ping-Pong Sample Streamer with Width Reshaping

This block sits between a bulk memory reader and a slow external capture device. Wide words arrive in bursts from the memory side and go into one of two on-chip banks. Meanwhile the other bank is played out as a steady trickle of narrow samples. Because the two banks alternate, the gaps and latency of the memory side never appear in the output stream, as long as each refill finishes before the bank being drained runs out.

The output side issues one narrow sample per fixed number of system clock cycles. With it go a generated sample clock and a data-valid flag, so the capture device can latch each sample on the rising edge of that clock. A pattern source can be selected in place of the buffered data. It drives a counting sequence through the same pacing and strobes, which allows loopback checks without loading memory.

A released bank is announced by a one-cycle refill request. The write side then streams exactly one bank's worth of words. The bank counts as full once its last word has been accepted.

Top module: `pingpong_sample_streamer`

## Requirements
- R1: The two banks are filled alternately, starting with bank 0 after reset, and drained in the same order: every sample of one bank comes out before any sample of the next.
- R2: Each accepted word is read back as WORD_W/SAMP_W samples. Bits [SAMP_W-1:0] come out first, then each next-higher SAMP_W-bit lane in turn. The read address is the word address with the lane index appended below it.
- R3: While a full bank or the pattern source is available, a new valid sample is issued every DIV system clock cycles, with no gaps and no repeats.
- R4: `samp_clk` has a period of DIV cycles and is high for DIV/2 of them. `samp_data` and `samp_valid` change only in the cycle in which `samp_clk` falls.
- R5: When the draining bank runs out and the other bank is not full, `samp_valid` goes low at the next issue point and `samp_data` keeps its last value. Output resumes once a full bank is available.
- R6: A bank is marked full when its DEPTH-th word is accepted. Releasing a drained bank raises `refill_req` for exactly one cycle.
- R7: A write presented while the bank targeted for filling is still full is dropped and leaves no trace in the output stream.
- R8: With `pat_sel` high, each issue point emits a SAMP_W-bit counter that starts at 0 after reset and goes up by one per emitted sample, at the same pacing. Buffered data is not consumed while the pattern source is selected.
- R9: Synchronous reset empties both banks, drives `samp_valid` and `samp_data` to 0, and returns the lane index, word pointers and bank selectors to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Wide word present on `wr_data` |
| wr_data | input | WORD_W | Wide word from the memory side |
| pat_sel | input | 1 | Select the counting pattern as the sample source |
| refill_req | output | 1 | One-cycle pulse: a drained bank is ready to be refilled |
| samp_clk | output | 1 | Generated sample clock, DIV-cycle period |
| samp_valid | output | 1 | Current sample is valid |
| samp_data | output | SAMP_W | Current sample |

## Verification
A wrong bank selector or a lost full flag shows at the ports within one sample period. It appears either as a sample carrying the wrong bank's tag or as `samp_valid` dropping while a full bank is waiting. A lane or word pointer that is off by one shifts the sample index encoded in the low byte of the data, so the very next sample after the fault is wrong. A fault in the pacing counter moves the `samp_clk` edges, and it is seen within a single DIV-cycle period.

// File: rtl/pps_pkg.sv
`timescale 1ns/1ps
package pps_pkg;

    typedef enum logic {
        SRC_BUF = 1'b0,
        SRC_PAT = 1'b1
    } src_e;

    function automatic int unsigned bits_for(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/pps_pace.sv
`timescale 1ns/1ps
module pps_pace #(
    parameter int unsigned DIV = 512
) (
    input  logic clk,
    input  logic rst,
    output logic tick,
    output logic samp_clk
);
    localparam int unsigned CW = pps_pkg::bits_for(DIV);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nxt;
    logic          sclk_q;

    assign tick    = (cnt_q == CW'(DIV - 1));
    assign cnt_nxt = tick ? '0 : cnt_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            sclk_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_nxt;
            sclk_q <= (cnt_nxt >= CW'(DIV / 2));
        end
    end

    assign samp_clk = sclk_q;

    p_tick_isolated_r3: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    p_fall_follows_tick_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(sclk_q) |-> $past(tick));

endmodule

// File: rtl/pps_store.sv
`timescale 1ns/1ps
module pps_store #(
    parameter int unsigned WORD_W = 128,
    parameter int unsigned SAMP_W = 16,
    parameter int unsigned DEPTH  = 1024
) (
    input  logic                                    clk,
    input  logic                                    we,
    input  logic                                    wbank,
    input  logic [pps_pkg::bits_for(DEPTH)-1:0]     waddr,
    input  logic [WORD_W-1:0]                       wdata,
    input  logic                                    rbank,
    input  logic [pps_pkg::bits_for(DEPTH)
                  + pps_pkg::bits_for(WORD_W/SAMP_W)-1:0] raddr,
    output logic [SAMP_W-1:0]                       rdata
);
    localparam int unsigned LANES = WORD_W / SAMP_W;
    localparam int unsigned AW    = pps_pkg::bits_for(DEPTH);
    localparam int unsigned LW    = pps_pkg::bits_for(LANES);

    logic [AW-1:0]     rword;
    logic [LW-1:0]     rlane;
    logic [WORD_W-1:0] bank_word [2];
    logic [WORD_W-1:0] sel_word;

    assign rword = raddr[AW+LW-1:LW];
    assign rlane = raddr[LW-1:0];

    for (genvar g = 0; g < 2; g++) begin : g_bank
        logic [WORD_W-1:0] mem [DEPTH];
        always_ff @(posedge clk) begin
            if (we && (wbank == 1'(g))) begin
                mem[waddr] <= wdata;
            end
        end
        assign bank_word[g] = mem[rword];
    end

    assign sel_word = bank_word[rbank];
    assign rdata    = sel_word[rlane * SAMP_W +: SAMP_W];

endmodule

// File: rtl/pps_wr_ctl.sv
`timescale 1ns/1ps
module pps_wr_ctl #(
    parameter int unsigned DEPTH = 1024
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                wr_en,
    input  logic                                rel_req,
    input  logic                                rel_bank,
    output logic [1:0]                          full,
    output logic                                we,
    output logic                                wbank,
    output logic [pps_pkg::bits_for(DEPTH)-1:0] waddr
);
    localparam int unsigned AW = pps_pkg::bits_for(DEPTH);

    logic [1:0]    full_q;
    logic          wbank_q;
    logic [AW-1:0] wptr_q;
    logic          accept;

    assign accept = wr_en && !full_q[wbank_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q  <= 2'b00;
            wbank_q <= 1'b0;
            wptr_q  <= '0;
        end else begin
            if (accept) begin
                if (wptr_q == AW'(DEPTH - 1)) begin
                    wptr_q          <= '0;
                    full_q[wbank_q] <= 1'b1;
                    wbank_q         <= ~wbank_q;
                end else begin
                    wptr_q <= wptr_q + 1'b1;
                end
            end
            if (rel_req) begin
                full_q[rel_bank] <= 1'b0;
            end
        end
    end

    assign full  = full_q;
    assign we    = accept;
    assign wbank = wbank_q;
    assign waddr = wptr_q;

    p_fill_needs_write_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(full_q[0]) |-> $past(wr_en));

    p_release_only_full_r1: assert property (@(posedge clk) disable iff (rst)
        rel_req |-> full_q[rel_bank]);

endmodule

// File: rtl/pps_rd_ctl.sv
`timescale 1ns/1ps
module pps_rd_ctl #(
    parameter int unsigned WORD_W = 128,
    parameter int unsigned SAMP_W = 16,
    parameter int unsigned DEPTH  = 1024
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    tick,
    input  logic                    pat_sel,
    input  logic [1:0]              full,
    input  logic [SAMP_W-1:0]       rd_sample,
    output logic                    rbank,
    output logic [pps_pkg::bits_for(DEPTH)
                  + pps_pkg::bits_for(WORD_W/SAMP_W)-1:0] raddr,
    output logic                    rel_req,
    output logic                    rel_bank,
    output logic                    refill_req,
    output logic                    samp_valid,
    output logic [SAMP_W-1:0]       samp_data
);
    import pps_pkg::*;

    localparam int unsigned LANES = WORD_W / SAMP_W;
    localparam int unsigned AW    = bits_for(DEPTH);
    localparam int unsigned LW    = bits_for(LANES);

    logic              rbank_q;
    logic [AW-1:0]     word_q;
    logic [LW-1:0]     lane_q;
    logic [SAMP_W-1:0] pat_q;
    logic [SAMP_W-1:0] data_q;
    logic              valid_q;
    logic              refill_q;
    src_e              src;
    logic              lane_last;
    logic              word_last;
    logic              consume;

    assign src       = pat_sel ? SRC_PAT : SRC_BUF;
    assign lane_last = (lane_q == LW'(LANES - 1));
    assign word_last = (word_q == AW'(DEPTH - 1));
    assign consume   = tick && (src == SRC_BUF) && full[rbank_q];
    assign rel_req   = consume && lane_last && word_last;
    assign rel_bank  = rbank_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rbank_q  <= 1'b0;
            word_q   <= '0;
            lane_q   <= '0;
            pat_q    <= '0;
            data_q   <= '0;
            valid_q  <= 1'b0;
            refill_q <= 1'b0;
        end else begin
            refill_q <= rel_req;
            if (tick) begin
                if (src == SRC_PAT) begin
                    data_q  <= pat_q;
                    pat_q   <= pat_q + 1'b1;
                    valid_q <= 1'b1;
                end else if (full[rbank_q]) begin
                    data_q  <= rd_sample;
                    valid_q <= 1'b1;
                    if (lane_last) begin
                        lane_q <= '0;
                        if (word_last) begin
                            word_q  <= '0;
                            rbank_q <= ~rbank_q;
                        end else begin
                            word_q <= word_q + 1'b1;
                        end
                    end else begin
                        lane_q <= lane_q + 1'b1;
                    end
                end else begin
                    valid_q <= 1'b0;
                end
            end
        end
    end

    assign rbank      = rbank_q;
    assign raddr      = {word_q, lane_q};
    assign refill_req = refill_q;
    assign samp_valid = valid_q;
    assign samp_data  = data_q;

    p_outputs_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !$past(tick) |-> ($stable(data_q) && $stable(valid_q)));

    p_refill_single_r6: assert property (@(posedge clk) disable iff (rst)
        refill_q |=> !refill_q);

    p_valid_has_source_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(valid_q) |-> $past(pat_sel || (full != 2'b00)));

endmodule

// File: rtl/pingpong_sample_streamer.sv
`timescale 1ns/1ps
module pingpong_sample_streamer #(
    parameter int unsigned WORD_W = 128,
    parameter int unsigned SAMP_W = 16,
    parameter int unsigned DEPTH  = 1024,
    parameter int unsigned DIV    = 512
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              pat_sel,
    output logic              refill_req,
    output logic              samp_clk,
    output logic              samp_valid,
    output logic [SAMP_W-1:0] samp_data
);
    localparam int unsigned LANES = WORD_W / SAMP_W;
    localparam int unsigned AW    = pps_pkg::bits_for(DEPTH);
    localparam int unsigned LW    = pps_pkg::bits_for(LANES);

    logic              tick;
    logic [1:0]        full;
    logic              we;
    logic              wbank;
    logic [AW-1:0]     waddr;
    logic              rbank;
    logic [AW+LW-1:0]  raddr;
    logic [SAMP_W-1:0] rd_sample;
    logic              rel_req;
    logic              rel_bank;

    pps_pace #(.DIV(DIV)) u_pace (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .samp_clk (samp_clk)
    );

    pps_wr_ctl #(.DEPTH(DEPTH)) u_wr (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .rel_req  (rel_req),
        .rel_bank (rel_bank),
        .full     (full),
        .we       (we),
        .wbank    (wbank),
        .waddr    (waddr)
    );

    pps_store #(.WORD_W(WORD_W), .SAMP_W(SAMP_W), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (we),
        .wbank (wbank),
        .waddr (waddr),
        .wdata (wr_data),
        .rbank (rbank),
        .raddr (raddr),
        .rdata (rd_sample)
    );

    pps_rd_ctl #(.WORD_W(WORD_W), .SAMP_W(SAMP_W), .DEPTH(DEPTH)) u_rd (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .pat_sel    (pat_sel),
        .full       (full),
        .rd_sample  (rd_sample),
        .rbank      (rbank),
        .raddr      (raddr),
        .rel_req    (rel_req),
        .rel_bank   (rel_bank),
        .refill_req (refill_req),
        .samp_valid (samp_valid),
        .samp_data  (samp_data)
    );

endmodule

// File: tb/test_pingpong_sample_streamer.sv
`timescale 1ns/1ps
module test_pingpong_sample_streamer;

    localparam int WORD_W = 128;
    localparam int SAMP_W = 16;
    localparam int DEPTH  = 4;
    localparam int DIV    = 8;
    localparam int LANES  = WORD_W / SAMP_W;
    localparam int PER_BANK = DEPTH * LANES;

    // stimulus: one tag per bank fill; expected sample n of a fill is {tag, n}
    localparam logic [7:0] TAGS [4] = '{8'h11, 8'h2C, 8'h3A, 8'hD4};

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [WORD_W-1:0] wr_data = '0;
    logic              pat_sel = 1'b0;
    logic              refill_req;
    logic              samp_clk;
    logic              samp_valid;
    logic [SAMP_W-1:0] samp_data;

    int n_cmp = 0;
    int n_bad = 0;
    int refill_cnt = 0;

    always #2 clk = ~clk;

    pingpong_sample_streamer #(
        .WORD_W(WORD_W), .SAMP_W(SAMP_W), .DEPTH(DEPTH), .DIV(DIV)
    ) i_pingpong_sample_streamer (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .pat_sel    (pat_sel),
        .refill_req (refill_req),
        .samp_clk   (samp_clk),
        .samp_valid (samp_valid),
        .samp_data  (samp_data)
    );

    always @(negedge clk) if (refill_req) refill_cnt++;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [WORD_W-1:0] word_of(input logic [7:0] tag, input int k);
        logic [WORD_W-1:0] w;
        for (int l = 0; l < LANES; l++) w[l*SAMP_W +: SAMP_W] = {tag, 8'(k * LANES + l)};
        return w;
    endfunction

    task automatic fill_bank(input logic [7:0] tag);
        for (int k = 0; k < DEPTH; k++) begin
            @(negedge clk);
            wr_en   = 1'b1;
            wr_data = word_of(tag, k);
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic next_sample(output logic v, output logic [SAMP_W-1:0] d);
        @(posedge samp_clk);
        #1;
        v = samp_valid;
        d = samp_data;
    endtask

    task automatic first_valid(output logic [SAMP_W-1:0] d);
        logic v = 1'b0;
        for (int t = 0; t < 20 && !v; t++) next_sample(v, d);
        check("R1 start", 32'(v), 32'd1);
    endtask

    task automatic drain_check(input logic [7:0] tag, input string req);
        logic v;
        logic [SAMP_W-1:0] d;
        first_valid(d);
        check(req, 32'(d), 32'({tag, 8'd0}));
        for (int n = 1; n < PER_BANK; n++) begin
            next_sample(v, d);
            check("R3 valid", 32'(v), 32'd1);
            check(req, 32'(d), 32'({tag, 8'(n)}));
        end
    endtask

    initial begin
        #(4 * 20000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic v;
        logic [SAMP_W-1:0] d;
        realtime t0, t1;
        int hi;

        repeat (5) @(negedge clk);
        check("R9 valid", 32'(samp_valid), 32'd0);
        check("R9 data", 32'(samp_data), 32'd0);
        check("R9 refill", 32'(refill_req), 32'd0);
        check("R9 sclk", 32'(samp_clk), 32'd0);
        rst = 1'b0;

        // R5: nothing loaded, nothing valid
        for (int j = 0; j < 2; j++) begin
            next_sample(v, d);
            check("R5 empty valid", 32'(v), 32'd0);
            check("R5 empty data", 32'(d), 32'd0);
        end

        fill_bank(TAGS[0]);
        fill_bank(TAGS[1]);
        // R7: both banks full, these words must vanish
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            wr_en = 1'b1;
            wr_data = '1;
        end
        @(negedge clk);
        wr_en = 1'b0;

        for (int i = 0; i < 4; i++) begin
            drain_check(TAGS[i], "R1 R2 R7 data");
            if (i == 0) check("R6 refill count", 32'(refill_cnt), 32'd1);
            if (i < 2) fill_bank(TAGS[i+2]);
        end
        check("R6 refill total", 32'(refill_cnt), 32'd4);

        // R5: starved, valid drops and data holds last sample
        for (int j = 0; j < 2; j++) begin
            next_sample(v, d);
            check("R5 starve valid", 32'(v), 32'd0);
            check("R5 hold data", 32'(d), 32'({TAGS[3], 8'(PER_BANK - 1)}));
        end

        // R4: period and duty of samp_clk
        @(posedge samp_clk);
        t0 = $realtime;
        hi = 0;
        for (int j = 0; j < DIV; j++) begin
            @(negedge clk);
            if (samp_clk) hi++;
        end
        @(posedge samp_clk);
        t1 = $realtime;
        check("R4 high cycles", 32'(hi), 32'(DIV / 2));
        check("R4 period ns", 32'(int'(t1 - t0)), 32'(DIV * 4));

        // R8: pattern source, buffer untouched
        next_sample(v, d);
        pat_sel = 1'b1;
        fill_bank(8'h5A);
        for (int k = 0; k < 6; k++) begin
            next_sample(v, d);
            check("R8 pat valid", 32'(v), 32'd1);
            check("R8 pat value", 32'(d), 32'(k));
        end
        pat_sel = 1'b0;
        drain_check(8'h5A, "R8 buffer kept");

        // R9: reset mid-stream clears flags and pointers
        fill_bank(8'h77);
        for (int j = 0; j < 4; j++) next_sample(v, d);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R9 mid valid", 32'(samp_valid), 32'd0);
        check("R9 mid data", 32'(samp_data), 32'd0);
        rst = 1'b0;
        next_sample(v, d);
        check("R9 flags cleared", 32'(v), 32'd0);
        fill_bank(8'h88);
        drain_check(8'h88, "R9 pointers zero");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule